// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a small multi-cycle processor in which one ALU and one unified memory are shared across the cycles of an instruction. A 4-bit state register selects a row of a control table. Each row gives the datapath control signals and a next-state code. That code is either a fixed successor state or a special dispatch code. The dispatch code tells the sequencer to choose the successor from the 3-bit opcode held in the instruction register.

Instructions take different numbers of cycles. Every instruction starts with a fetch and a decode cycle. Arithmetic and stores then take two more cycles, loads take three, and branches take two. The branch compare cycle loads the PC only when the ALU equality flag is set. A halt instruction parks the sequencer in a terminal state with every enable low until reset.

The named states are: FETCH(0), DECODE(1), ADD_EXEC(2), ADD_WB(3), NOR_EXEC(4), NOR_WB(5), LW_ADDR(6), LW_MEM(7), LW_WB(8), SW_ADDR(9), SW_MEM(10), BEQ_TGT(11), BEQ_CMP(12) and HALTED(13). The transitions are as follows. Reset goes to FETCH. FETCH goes to DECODE. DECODE dispatches on the opcode. The fixed chains are ADD_EXEC→ADD_WB, NOR_EXEC→NOR_WB, LW_ADDR→LW_MEM→LW_WB, SW_ADDR→SW_MEM and BEQ_TGT→BEQ_CMP. ADD_WB, NOR_WB, LW_WB, SW_MEM and BEQ_CMP all return to FETCH. HALTED stays in HALTED.

Top module: `mcc_control_fsm`

## Requirements
- R1: While reset (rst_n low) is asserted and in the first cycle after it is released, the state is FETCH (0). In FETCH: mem_en=1, mem_wr=0, addr_sel=0 (PC), ir_en=1, alu_a_sel=0 (PC), alu_b_sel=01 (constant one), alu_op=00 (add), and all other enables are 0.
- R2: DECODE (1) follows FETCH. DECODE asserts only pc_en. It dispatches on the opcode: 000 (add) to ADD_EXEC (2), 001 (nor) to NOR_EXEC (4), 010 (lw) to LW_ADDR (6), 011 (sw) to SW_ADDR (9), 100 (beq) to BEQ_TGT (11).
- R3: ADD_EXEC drives alu_a_sel=1, alu_b_sel=00, alu_op=00. NOR_EXEC drives the same selects with alu_op=01. The writeback states ADD_WB (3) and NOR_WB (5) drive dest_sel=1, wdata_sel=1 (ALU result) and rf_we=1, then return to FETCH.
- R4: A load runs LW_ADDR (alu_a_sel=1, alu_b_sel=11, add), then LW_MEM (addr_sel=1, mem_en=1, mem_wr=0), then LW_WB (rf_we=1, dest_sel=0, wdata_sel=0 memory data), then FETCH.
- R5: A store runs SW_ADDR (same controls as LW_ADDR), then SW_MEM (addr_sel=1, mem_en=1, mem_wr=1), then FETCH.
- R6: A branch runs BEQ_TGT (alu_a_sel=0, alu_b_sel=11, add), then BEQ_CMP (alu_a_sel=1, alu_b_sel=00, alu_op=10 compare), then FETCH. In BEQ_CMP, pc_en equals alu_eq.
- R7: Opcodes 111 (noop) and 101 (not executed by this unit) return from DECODE straight to FETCH.
- R8: Opcode 110 (halt) moves DECODE to HALTED (13). HALTED keeps every output at 0 and stays there for any opcode or alu_eq until reset.
- R9: Outside DECODE the opcode has no effect on the successor. Outside BEQ_CMP, alu_eq has no effect on any output.
- R10: mem_wr is never 1 without mem_en, and rf_we is never 1 together with mem_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 3 | Opcode field of the instruction register |
| alu_eq | input | 1 | ALU equality flag |
| pc_en | output | 1 | PC write enable |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALU result |
| mem_en | output | 1 | Memory access enable |
| mem_wr | output | 1 | Memory direction: 1 write, 0 read |
| ir_en | output | 1 | Instruction register write enable |
| dest_sel | output | 1 | Destination register field: 1 dest field, 0 regB field |
| wdata_sel | output | 1 | Register write data: 1 ALU result, 0 memory data |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 regA |
| alu_b_sel | output | 2 | ALU operand B: 00 regB, 01 one, 11 sign-extended offset |
| alu_op | output | 2 | ALU function: 00 add, 01 nor, 10 compare |
| state_o | output | 4 | Current state code |

## Verification
The bench walks each instruction class through its full state chain and checks every control output in every cycle. This catches a wrong dispatch target or a broken fixed successor, which would show up as a wrong state code or control word one cycle later. Branches run with the equality flag both low and high. A design that ignores the flag, or lets it act in other states, would load the PC on an untaken branch or during arithmetic. The bench changes the opcode in the middle of a sequence. A design that decodes outside DECODE would jump chains. Halt is held across changing opcodes and equality values and then cleared by reset. A leaky halted state would either assert an enable or wander back to FETCH.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int STATE_W = 4;
    localparam int OPC_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_ADD_EXEC = 4'd2,
        ST_ADD_WB   = 4'd3,
        ST_NOR_EXEC = 4'd4,
        ST_NOR_WB   = 4'd5,
        ST_LW_ADDR  = 4'd6,
        ST_LW_MEM   = 4'd7,
        ST_LW_WB    = 4'd8,
        ST_SW_ADDR  = 4'd9,
        ST_SW_MEM   = 4'd10,
        ST_BEQ_TGT  = 4'd11,
        ST_BEQ_CMP  = 4'd12,
        ST_HALTED   = 4'd13
    } state_t;

    // Next-state code meaning "choose the successor from the opcode"
    localparam logic [STATE_W-1:0] NXT_DISPATCH = '1;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 3'd0,
        OPC_NOR  = 3'd1,
        OPC_LW   = 3'd2,
        OPC_SW   = 3'd3,
        OPC_BEQ  = 3'd4,
        OPC_JALR = 3'd5,
        OPC_HALT = 3'd6,
        OPC_NOOP = 3'd7
    } opcode_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_NOR = 2'b01,
        ALU_EQ  = 2'b10
    } alu_op_t;

    localparam logic [1:0] BSEL_REGB = 2'b00;
    localparam logic [1:0] BSEL_ONE  = 2'b01;
    localparam logic [1:0] BSEL_OFFS = 2'b11;

    typedef struct packed {
        logic       pc_en;
        logic       pc_on_eq;
        logic       addr_sel;
        logic       mem_en;
        logic       mem_wr;
        logic       ir_en;
        logic       dest_sel;
        logic       wdata_sel;
        logic       rf_we;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        alu_op_t    alu_op;
    } ctrl_t;

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
    import mcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t nxt_state,
    output state_t cur_state
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_state <= ST_FETCH;
        end else begin
            cur_state <= nxt_state;
        end
    end

endmodule

// File: rtl/mcc_ctrl_rom.sv
module mcc_ctrl_rom
    import mcc_pkg::*;
(
    input  state_t             cur_state,
    output ctrl_t              ctrl,
    output logic [STATE_W-1:0] nxt_code
);

    always_comb begin
        ctrl           = '0;
        ctrl.alu_op    = ALU_ADD;
        ctrl.alu_b_sel = BSEL_REGB;
        nxt_code       = ST_FETCH;
        unique case (cur_state)
            ST_FETCH: begin
                ctrl.mem_en    = 1'b1;
                ctrl.ir_en     = 1'b1;
                ctrl.alu_b_sel = BSEL_ONE;
                nxt_code       = ST_DECODE;
            end
            ST_DECODE: begin
                ctrl.pc_en = 1'b1;
                nxt_code   = NXT_DISPATCH;
            end
            ST_ADD_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                nxt_code       = ST_ADD_WB;
            end
            ST_NOR_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_op    = ALU_NOR;
                nxt_code       = ST_NOR_WB;
            end
            ST_ADD_WB, ST_NOR_WB: begin
                ctrl.dest_sel  = 1'b1;
                ctrl.wdata_sel = 1'b1;
                ctrl.rf_we     = 1'b1;
                nxt_code       = ST_FETCH;
            end
            ST_LW_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_OFFS;
                nxt_code       = ST_LW_MEM;
            end
            ST_LW_MEM: begin
                ctrl.addr_sel = 1'b1;
                ctrl.mem_en   = 1'b1;
                nxt_code      = ST_LW_WB;
            end
            ST_LW_WB: begin
                ctrl.rf_we = 1'b1;
                nxt_code   = ST_FETCH;
            end
            ST_SW_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_OFFS;
                nxt_code       = ST_SW_MEM;
            end
            ST_SW_MEM: begin
                ctrl.addr_sel = 1'b1;
                ctrl.mem_en   = 1'b1;
                ctrl.mem_wr   = 1'b1;
                nxt_code      = ST_FETCH;
            end
            ST_BEQ_TGT: begin
                ctrl.alu_b_sel = BSEL_OFFS;
                nxt_code       = ST_BEQ_CMP;
            end
            ST_BEQ_CMP: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_op    = ALU_EQ;
                ctrl.pc_on_eq  = 1'b1;
                nxt_code       = ST_FETCH;
            end
            ST_HALTED: begin
                nxt_code = ST_HALTED;
            end
            default: begin
                nxt_code = ST_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/mcc_next_sel.sv
module mcc_next_sel
    import mcc_pkg::*;
(
    input  logic [STATE_W-1:0] nxt_code,
    input  logic [OPC_W-1:0]   opcode,
    output state_t             nxt_state
);

    state_t dispatch_tgt;

    always_comb begin
        unique case (opcode_t'(opcode))
            OPC_ADD:  dispatch_tgt = ST_ADD_EXEC;
            OPC_NOR:  dispatch_tgt = ST_NOR_EXEC;
            OPC_LW:   dispatch_tgt = ST_LW_ADDR;
            OPC_SW:   dispatch_tgt = ST_SW_ADDR;
            OPC_BEQ:  dispatch_tgt = ST_BEQ_TGT;
            OPC_HALT: dispatch_tgt = ST_HALTED;
            default:  dispatch_tgt = ST_FETCH;
        endcase
    end

    always_comb begin
        if (nxt_code == NXT_DISPATCH) begin
            nxt_state = dispatch_tgt;
        end else begin
            nxt_state = state_t'(nxt_code);
        end
    end

endmodule

// File: rtl/mcc_control_fsm.sv
module mcc_control_fsm
    import mcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               alu_eq,
    output logic               pc_en,
    output logic               addr_sel,
    output logic               mem_en,
    output logic               mem_wr,
    output logic               ir_en,
    output logic               dest_sel,
    output logic               wdata_sel,
    output logic               rf_we,
    output logic               alu_a_sel,
    output logic [1:0]         alu_b_sel,
    output logic [1:0]         alu_op,
    output logic [STATE_W-1:0] state_o
);

    state_t             cur_state;
    state_t             nxt_state;
    ctrl_t              ctrl;
    logic [STATE_W-1:0] nxt_code;

    mcc_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    mcc_ctrl_rom u_rom (
        .cur_state (cur_state),
        .ctrl      (ctrl),
        .nxt_code  (nxt_code)
    );

    mcc_next_sel u_next (
        .nxt_code  (nxt_code),
        .opcode    (opcode),
        .nxt_state (nxt_state)
    );

    // Conditional PC load in the branch compare state
    assign pc_en     = ctrl.pc_en | (ctrl.pc_on_eq & alu_eq);
    assign addr_sel  = ctrl.addr_sel;
    assign mem_en    = ctrl.mem_en;
    assign mem_wr    = ctrl.mem_wr;
    assign ir_en     = ctrl.ir_en;
    assign dest_sel  = ctrl.dest_sel;
    assign wdata_sel = ctrl.wdata_sel;
    assign rf_we     = ctrl.rf_we;
    assign alu_a_sel = ctrl.alu_a_sel;
    assign alu_b_sel = ctrl.alu_b_sel;
    assign alu_op    = ctrl.alu_op;
    assign state_o   = cur_state;

    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_FETCH) |=> (cur_state == ST_DECODE));

    a_r2_add_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_DECODE && opcode == OPC_ADD) |=> (cur_state == ST_ADD_EXEC));

    a_r4_lw_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_LW_ADDR) |=> (cur_state == ST_LW_MEM && mem_en && !mem_wr));

    a_r6_cmp_pc_follows_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_BEQ_CMP) |-> (pc_en == alu_eq));

    a_r8_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_HALTED) |=> (cur_state == ST_HALTED));

    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_HALTED) |-> !(pc_en || mem_en || rf_we || ir_en));

    a_r9_pc_en_only_decode_or_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |-> (cur_state == ST_DECODE || cur_state == ST_BEQ_CMP));

    a_r10_wr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_en);

    a_r10_no_rf_and_mem: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && mem_en));

endmodule

// File: tb/test_mcc_control_fsm.sv
module test_mcc_control_fsm;

    logic       clk;
    logic       rst_n;
    logic [2:0] opcode;
    logic       alu_eq;
    logic       pc_en, addr_sel, mem_en, mem_wr, ir_en, dest_sel, wdata_sel, rf_we, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op;
    logic [3:0] state_o;

    int n_run;
    int n_fail;

    mcc_control_fsm i_mcc_control_fsm (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_eq(alu_eq),
        .pc_en(pc_en), .addr_sel(addr_sel), .mem_en(mem_en), .mem_wr(mem_wr),
        .ir_en(ir_en), .dest_sel(dest_sel), .wdata_sel(wdata_sel), .rf_we(rf_we),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .state_o(state_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Control word as seen at the ports:
    // {pc_en, addr_sel, mem_en, mem_wr, ir_en, dest_sel, wdata_sel, rf_we, alu_a_sel, alu_b_sel, alu_op}
    localparam logic [12:0] CW_FETCH = 13'h0504;
    localparam logic [12:0] CW_DEC   = 13'h1000;
    localparam logic [12:0] CW_ADDX  = 13'h0010;
    localparam logic [12:0] CW_NORX  = 13'h0011;
    localparam logic [12:0] CW_WBALU = 13'h00E0;
    localparam logic [12:0] CW_MADDR = 13'h001C;
    localparam logic [12:0] CW_LWMEM = 13'h0C00;
    localparam logic [12:0] CW_LWWB  = 13'h0020;
    localparam logic [12:0] CW_SWMEM = 13'h0E00;
    localparam logic [12:0] CW_BTGT  = 13'h000C;
    localparam logic [12:0] CW_BCMP0 = 13'h0012;
    localparam logic [12:0] CW_BCMP1 = 13'h1012;
    localparam logic [12:0] CW_ZERO  = 13'h0000;

    // Row: {req[3:0], opcode[2:0], alu_eq, state[3:0], cw[12:0]}
    localparam int NV = 29;
    localparam logic [24:0] VEC [NV] = '{
        // R3 add, alu_eq high outside compare (R9)
        {4'd1, 3'd0, 1'b1, 4'd0,  CW_FETCH},
        {4'd2, 3'd0, 1'b1, 4'd1,  CW_DEC},
        {4'd3, 3'd6, 1'b1, 4'd2,  CW_ADDX},
        {4'd3, 3'd4, 1'b1, 4'd3,  CW_WBALU},
        // R3 nor, opcode changed mid-chain (R9)
        {4'd1, 3'd1, 1'b0, 4'd0,  CW_FETCH},
        {4'd2, 3'd1, 1'b0, 4'd1,  CW_DEC},
        {4'd9, 3'd2, 1'b0, 4'd4,  CW_NORX},
        {4'd3, 3'd6, 1'b0, 4'd5,  CW_WBALU},
        // R4 lw
        {4'd1, 3'd2, 1'b0, 4'd0,  CW_FETCH},
        {4'd2, 3'd2, 1'b0, 4'd1,  CW_DEC},
        {4'd4, 3'd0, 1'b0, 4'd6,  CW_MADDR},
        {4'd4, 3'd6, 1'b1, 4'd7,  CW_LWMEM},
        {4'd4, 3'd1, 1'b0, 4'd8,  CW_LWWB},
        // R5 sw
        {4'd1, 3'd3, 1'b0, 4'd0,  CW_FETCH},
        {4'd2, 3'd3, 1'b0, 4'd1,  CW_DEC},
        {4'd5, 3'd6, 1'b0, 4'd9,  CW_MADDR},
        {4'd5, 3'd3, 1'b0, 4'd10, CW_SWMEM},
        // R6 beq not equal
        {4'd1, 3'd4, 1'b0, 4'd0,  CW_FETCH},
        {4'd2, 3'd4, 1'b0, 4'd1,  CW_DEC},
        {4'd6, 3'd4, 1'b1, 4'd11, CW_BTGT},
        {4'd6, 3'd4, 1'b0, 4'd12, CW_BCMP0},
        // R6 beq equal
        {4'd1, 3'd4, 1'b1, 4'd0,  CW_FETCH},
        {4'd2, 3'd4, 1'b1, 4'd1,  CW_DEC},
        {4'd6, 3'd4, 1'b1, 4'd11, CW_BTGT},
        {4'd6, 3'd4, 1'b1, 4'd12, CW_BCMP1},
        // R7 noop then opcode 5
        {4'd1, 3'd7, 1'b0, 4'd0,  CW_FETCH},
        {4'd7, 3'd7, 1'b0, 4'd1,  CW_DEC},
        {4'd1, 3'd5, 1'b0, 4'd0,  CW_FETCH},
        {4'd7, 3'd5, 1'b0, 4'd1,  CW_DEC}
    };

    function automatic logic [12:0] port_cw();
        return {pc_en, addr_sel, mem_en, mem_wr, ir_en, dest_sel, wdata_sel,
                rf_we, alu_a_sel, alu_b_sel, alu_op};
    endfunction

    task automatic check(input int req, input logic [3:0] st, input logic [12:0] cw);
        n_run++;
        if (state_o !== st || port_cw() !== cw) begin
            n_fail++;
            $display("FAIL R%0d: state=%0d cw=%h expected state=%0d cw=%h",
                     req, state_o, port_cw(), st, cw);
        end
    endtask

    bit done;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R0: watchdog expired, actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        n_run  = 0;
        n_fail = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        opcode = 3'd4;
        alu_eq = 1'b1;
        repeat (3) @(negedge clk);
        #1 check(1, 4'd0, CW_FETCH);      // R1 held in reset
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            opcode = VEC[i][20:18];
            alu_eq = VEC[i][17];
            #1 check(int'(VEC[i][24:21]), VEC[i][16:13], VEC[i][12:0]);
            @(negedge clk);
        end

        // R8 halt: enter and stay with changing inputs
        opcode = 3'd6; alu_eq = 1'b0;
        #1 check(1, 4'd0, CW_FETCH);
        @(negedge clk);
        #1 check(2, 4'd1, CW_DEC);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            opcode = 3'(k);
            alu_eq = k[0];
            #1 check(8, 4'd13, CW_ZERO);   // R8 parked, R9 inputs ignored
            @(negedge clk);
        end

        // R8 only reset leaves halt
        rst_n = 1'b0;
        #1 check(8, 4'd0, CW_FETCH);
        @(negedge clk);
        rst_n = 1'b1;
        opcode = 3'd0; alu_eq = 1'b0;
        #1 check(1, 4'd0, CW_FETCH);
        @(negedge clk);
        #1 check(2, 4'd1, CW_DEC);
        @(negedge clk);
        #1 check(3, 4'd2, CW_ADDX);
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule